// File: doc/BRIEF.md
# Two-Link Byte-Interleaved TDM Multiplexer

This block carries the system-side traffic of two independent links over one pair of high-rate serial lines, one line per direction. In the outbound direction, each link supplies one byte per timeslot on request. The block sends these bytes on a single serial output, alternating between the links one whole byte at a time. In the inbound direction, it takes the matching interleaved serial input apart again. It hands each received byte out together with its timeslot index and a strobe that names the owning link.

Every serial bit is launched and sampled on the rising edge of the one bus clock. The bus runs at one of two rates. At the base rate, one bit lasts one clock cycle and a frame is 1024 bits. At double rate, each bit lasts two clock cycles and is sampled on the second. An external frame-start pulse, whose active level is selectable, fixes where the frame starts. It may come once per frame or at any whole multiple of the frame length. Between pulses, the internal bit counter runs on by itself.

Top module: `tdm_pair_mux`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `ser_out`, `rx_vld_a`, `rx_vld_b`, `align_err` and `rx_byte` are all 0, and the bit counter stands at frame bit 0.
- R2: Byte slot s of a frame covers frame bits 8s to 8s+7. An even s belongs to link A and an odd s to link B, and the timeslot index is s/2 (0 to 63 at the default of 128 slots). In each cycle where the block fetches the next slot's byte, `tx_req_a` or `tx_req_b` is high for that slot and `tx_ts` gives its timeslot.
- R3: Each byte goes out on `ser_out` most significant bit first, one bit per bit period.
- R4: A fetch happens in the last cycle of every byte slot, and also in any cycle where an active frame pulse is sampled. In that second case the fetched slot is slot 0. The byte on `tx_byte_a` or `tx_byte_b` is taken at that clock edge, and its MSB is on `ser_out` in the following cycle.
- R5: `ser_in` is sampled in the last cycle of each bit period. One cycle after the edge that samples bit 7 of a slot, `rx_byte` holds the slot's byte (first bit received in bit 7), `rx_ts` holds its timeslot, and exactly one of `rx_vld_a`/`rx_vld_b` pulses for one cycle, chosen by the slot parity.
- R6: With `fast_rate` = 1, each bit period lasts two cycles. The bit counter advances and `ser_in` is sampled only on the second cycle.
- R7: The frame pulse is active when `fp_in` equals `fp_pol` (1 = active high, 0 = active low). A level that differs from `fp_pol` has no effect.
- R8: After an active pulse is sampled, the next cycle is frame bit 0, phase 0. If the pulse came in any cycle other than the last cycle of the frame, `align_err` is high for exactly that next cycle. Otherwise it stays low.
- R9: With no frame pulse, the counter wraps from the last bit of the frame (1023 by default) to bit 0 and keeps running.
- R10: The slot in progress when reset is released sends all-zero bits, because no byte has been fetched yet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Multiplexed bus clock; all activity on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| fast_rate | input | 1 | 1: each bit spans two clock cycles; 0: one cycle |
| fp_in | input | 1 | Frame-start pulse, sampled each clock |
| fp_pol | input | 1 | Active level of `fp_in` |
| tx_byte_a | input | 8 | Link A byte for the slot being fetched |
| tx_byte_b | input | 8 | Link B byte for the slot being fetched |
| tx_req_a | output | 1 | Fetch strobe for link A (combinational) |
| tx_req_b | output | 1 | Fetch strobe for link B (combinational) |
| tx_ts | output | 6 | Timeslot index of the slot being fetched |
| ser_out | output | 1 | Multiplexed serial output |
| ser_in | input | 1 | Multiplexed serial input |
| rx_byte | output | 8 | Last completed received byte |
| rx_ts | output | 6 | Timeslot index of `rx_byte` |
| rx_vld_a | output | 1 | One-cycle strobe: `rx_byte` belongs to link A |
| rx_vld_b | output | 1 | One-cycle strobe: `rx_byte` belongs to link B |
| align_err | output | 1 | One-cycle flag: frame pulse came off the counter's frame end |

## Verification
The fetch strobes and `tx_ts` depend combinationally on the sampled pulse, so they are due in the same cycle as the stimulus. The bench checks them one time unit after it drives its inputs on the falling edge. `ser_out`, the received byte, its strobes and `align_err` are all one register away from the edge that samples their cause. The bench therefore moves its reference model forward at each rising edge and compares those outputs at the next falling edge. Pulses are placed on the final frame cycle, at arbitrary points, and in the middle of a double-rate bit, under both polarities.

// File: rtl/tdm_pair_pkg.sv
// Shared constants and types for the two-link TDM multiplexer.
// Assumes byte-wide slots; the bit-in-byte index is the low bits of the counter.
package tdm_pair_pkg;
    localparam int BYTE_W    = 8;
    localparam int BIT_IDX_W = 3;

    typedef enum logic {
        LINK_A = 1'b0,
        LINK_B = 1'b1
    } link_e;
endpackage

// File: rtl/tdm_frame_timer.sv
// Frame timer: tracks the current bit of the frame and the phase within a bit.
// It realigns on an active frame pulse and flags any pulse that does not fall
// on the counter's own frame end.
// Assumes SLOTS is a power of two and fast_rate changes only at a realignment.
module tdm_frame_timer
    import tdm_pair_pkg::*;
#(
    parameter  int SLOTS      = 128,
    localparam int FRAME_BITS = SLOTS * BYTE_W,
    localparam int POS_W      = $clog2(FRAME_BITS),
    localparam int SLOT_W     = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fast_rate,
    input  logic              fp_in,
    input  logic              fp_pol,
    output logic [POS_W-1:0]  pos,
    output logic              bit_end,
    output logic              load,
    output logic [SLOT_W-1:0] next_slot,
    output logic              align_err
);
    logic ph;
    logic fp_act;
    logic byte_end;
    logic frame_end;

    // Decode pulse polarity and the bit, byte and frame boundaries.
    always_comb begin
        fp_act    = fp_pol ? fp_in : ~fp_in;
        bit_end   = fast_rate ? ph : 1'b1;
        byte_end  = bit_end && (&pos[BIT_IDX_W-1:0]);
        frame_end = bit_end && (pos == POS_W'(FRAME_BITS - 1));
        load      = byte_end || fp_act;
        next_slot = fp_act ? '0 : SLOT_W'(pos[POS_W-1:BIT_IDX_W] + 1'b1);
    end

    // Advance the bit counter, or realign it and report any misalignment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos       <= '0;
            ph        <= 1'b0;
            align_err <= 1'b0;
        end else begin
            align_err <= fp_act && !frame_end;
            if (fp_act) begin
                pos <= '0;
                ph  <= 1'b0;
            end else if (fast_rate && !ph) begin
                ph <= 1'b1;
            end else begin
                ph  <= 1'b0;
                pos <= frame_end ? '0 : pos + 1'b1;
            end
        end
    end

    assert_realign_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fp_act |=> (pos == '0 && !ph));
    assert_err_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        align_err |-> $past(fp_act));
    assert_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!fp_act && frame_end) |=> (pos == '0));
    assert_fast_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fast_rate && !ph && !fp_act) |=> $stable(pos));
endmodule

// File: rtl/tdm_tx_serializer.sv
// Transmit serializer: fetches one byte per slot from the owning link and
// shifts it out MSB first, one bit per bit period.
// Assumes the requested byte is valid at the clock edge of the fetch cycle.
module tdm_tx_serializer
    import tdm_pair_pkg::*;
#(
    parameter  int SLOT_W = 7,
    localparam int TS_W   = SLOT_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              bit_end,
    input  logic [SLOT_W-1:0] next_slot,
    input  logic [BYTE_W-1:0] byte_a,
    input  logic [BYTE_W-1:0] byte_b,
    output logic [1:0]        req,
    output logic [TS_W-1:0]   ts,
    output logic              ser_out
);
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] load_byte;

    // One fetch strobe per link, chosen by the parity of the next slot.
    for (genvar l = 0; l < 2; l++) begin : g_req
        assign req[l] = load && (next_slot[0] == 1'(l));
    end

    // Select the owning link's byte and timeslot for the fetch.
    always_comb begin
        load_byte = (link_e'(next_slot[0]) == LINK_B) ? byte_b : byte_a;
        ts        = next_slot[SLOT_W-1:1];
        ser_out   = shreg[BYTE_W-1];
    end

    // Load a new byte at the slot boundary, otherwise shift at each bit end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
        end else if (load) begin
            shreg <= load_byte;
        end else if (bit_end) begin
            shreg <= {shreg[BYTE_W-2:0], 1'b0};
        end
    end

    assert_load_msb_R4: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (ser_out == $past(load_byte[BYTE_W-1])));
    assert_req_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req));
endmodule

// File: rtl/tdm_rx_deserializer.sv
// Receive deserializer: samples the serial input at the end of each bit
// period and, after the eighth bit of a slot, presents the byte with its
// timeslot and a one-cycle strobe for the owning link.
// Assumes the position input is the bit currently on the bus.
module tdm_rx_deserializer
    import tdm_pair_pkg::*;
#(
    parameter  int POS_W  = 10,
    localparam int SLOT_W = POS_W - BIT_IDX_W,
    localparam int TS_W   = SLOT_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_end,
    input  logic [POS_W-1:0]  pos,
    input  logic              ser_in,
    output logic [BYTE_W-1:0] rx_byte,
    output logic [TS_W-1:0]   rx_ts,
    output logic [1:0]        vld
);
    logic [BYTE_W-1:0] shreg;
    logic [SLOT_W-1:0] slot;
    logic              last_bit;

    // Split the position into slot and last-bit-of-byte.
    always_comb begin
        slot     = pos[POS_W-1:BIT_IDX_W];
        last_bit = &pos[BIT_IDX_W-1:0];
    end

    // Shift in sampled bits and emit a completed byte with its owner.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg   <= '0;
            rx_byte <= '0;
            rx_ts   <= '0;
            vld     <= '0;
        end else begin
            vld <= '0;
            if (bit_end) begin
                shreg <= {shreg[BYTE_W-2:0], ser_in};
                if (last_bit) begin
                    rx_byte        <= {shreg[BYTE_W-2:0], ser_in};
                    rx_ts          <= slot[SLOT_W-1:1];
                    vld[slot[0]]   <= 1'b1;
                end
            end
        end
    end

    assert_vld_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(vld));
    assert_vld_after_sample_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|vld) |-> $past(bit_end));
endmodule

// File: rtl/tdm_pair_mux.sv
// Top level: two-link byte-interleaved multiplexer and demultiplexer on one
// serial bus clock. Assumes one clock domain; the frame pulse and serial
// input are synchronous to clk.
module tdm_pair_mux
    import tdm_pair_pkg::*;
#(
    parameter  int SLOTS      = 128,
    localparam int FRAME_BITS = SLOTS * BYTE_W,
    localparam int POS_W      = $clog2(FRAME_BITS),
    localparam int SLOT_W     = $clog2(SLOTS),
    localparam int TS_W       = SLOT_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fast_rate,
    input  logic              fp_in,
    input  logic              fp_pol,
    input  logic [BYTE_W-1:0] tx_byte_a,
    input  logic [BYTE_W-1:0] tx_byte_b,
    output logic              tx_req_a,
    output logic              tx_req_b,
    output logic [TS_W-1:0]   tx_ts,
    output logic              ser_out,
    input  logic              ser_in,
    output logic [BYTE_W-1:0] rx_byte,
    output logic [TS_W-1:0]   rx_ts,
    output logic              rx_vld_a,
    output logic              rx_vld_b,
    output logic              align_err
);
    logic [POS_W-1:0]  pos;
    logic              bit_end;
    logic              load;
    logic [SLOT_W-1:0] next_slot;
    logic [1:0]        req;
    logic [1:0]        vld;

    tdm_frame_timer #(.SLOTS(SLOTS)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .fast_rate (fast_rate),
        .fp_in     (fp_in),
        .fp_pol    (fp_pol),
        .pos       (pos),
        .bit_end   (bit_end),
        .load      (load),
        .next_slot (next_slot),
        .align_err (align_err)
    );

    tdm_tx_serializer #(.SLOT_W(SLOT_W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .bit_end   (bit_end),
        .next_slot (next_slot),
        .byte_a    (tx_byte_a),
        .byte_b    (tx_byte_b),
        .req       (req),
        .ts        (tx_ts),
        .ser_out   (ser_out)
    );

    tdm_rx_deserializer #(.POS_W(POS_W)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_end (bit_end),
        .pos     (pos),
        .ser_in  (ser_in),
        .rx_byte (rx_byte),
        .rx_ts   (rx_ts),
        .vld     (vld)
    );

    // Map the per-link vectors onto named ports.
    always_comb begin
        tx_req_a = req[LINK_A];
        tx_req_b = req[LINK_B];
        rx_vld_a = vld[LINK_A];
        rx_vld_b = vld[LINK_B];
    end
endmodule

// File: tb/tdm_pair_mux_test.sv
// Bench: behavioural reference model advanced on each rising edge, and
// compared with the design on every cycle.
module tdm_pair_mux_test;
    localparam int SLOTS = 128;
    localparam int FB    = SLOTS * 8;

    logic       clk = 1'b0;
    logic       rst_n, fast_rate, fp_in, fp_pol, ser_in;
    logic [7:0] tx_byte_a, tx_byte_b;
    logic       tx_req_a, tx_req_b, ser_out, rx_vld_a, rx_vld_b, align_err;
    logic [5:0] tx_ts, rx_ts;
    logic [7:0] rx_byte;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;
    string scen = "R1 reset";

    int m_pos, m_ph, m_tx, m_rx_sr, m_rx_byte, m_rx_ts, m_va, m_vb, m_err;

    tdm_pair_mux #(.SLOTS(SLOTS)) uut (
        .clk(clk), .rst_n(rst_n), .fast_rate(fast_rate), .fp_in(fp_in),
        .fp_pol(fp_pol), .tx_byte_a(tx_byte_a), .tx_byte_b(tx_byte_b),
        .tx_req_a(tx_req_a), .tx_req_b(tx_req_b), .tx_ts(tx_ts),
        .ser_out(ser_out), .ser_in(ser_in), .rx_byte(rx_byte), .rx_ts(rx_ts),
        .rx_vld_a(rx_vld_a), .rx_vld_b(rx_vld_b), .align_err(align_err)
    );

    always #5 clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL [%s] %s: actual %0d expected %0d at pos %0d",
                     scen, tag, act, exp, m_pos);
        end
    endtask

    // One bus cycle: drive at the falling edge, check the fetch outputs,
    // advance the model at the rising edge, check registered outputs after it.
    task automatic cycle(input bit pulse);
        bit act, bitend, fend, load, sd;
        int nslot, a, b;
        fp_in     = pulse ? fp_pol : ~fp_pol;
        ser_in    = 1'($urandom);
        tx_byte_a = 8'($urandom);
        tx_byte_b = 8'($urandom);
        #1;
        act    = pulse;
        bitend = fast_rate ? (m_ph == 1) : 1'b1;
        fend   = bitend && (m_pos == FB - 1);
        load   = (bitend && (m_pos % 8 == 7)) || act;
        nslot  = act ? 0 : ((m_pos / 8) + 1) % SLOTS;
        chk("R2 tx_req_a", int'(tx_req_a), int'(load && (nslot % 2 == 0)));
        chk("R2 tx_req_b", int'(tx_req_b), int'(load && (nslot % 2 == 1)));
        if (load) chk("R2 R4 tx_ts", int'(tx_ts), nslot / 2);
        sd = ser_in; a = tx_byte_a; b = tx_byte_b;
        @(posedge clk);
        m_err = int'(act && !fend);
        m_va = 0; m_vb = 0;
        if (bitend) begin
            if (m_pos % 8 == 7) begin
                m_rx_byte = ((m_rx_sr << 1) | int'(sd)) & 255;
                m_rx_ts   = (m_pos / 8) / 2;
                if ((m_pos / 8) % 2 == 1) m_vb = 1; else m_va = 1;
            end
            m_rx_sr = ((m_rx_sr << 1) | int'(sd)) & 255;
        end
        if (load) m_tx = (nslot % 2 == 1) ? b : a;
        else if (bitend) m_tx = (m_tx << 1) & 255;
        if (act) begin
            m_pos = 0; m_ph = 0;
        end else if (fast_rate && m_ph == 0) begin
            m_ph = 1;
        end else begin
            m_ph = 0;
            m_pos = fend ? 0 : m_pos + 1;
        end
        @(negedge clk);
        chk("R3 R4 R10 ser_out", int'(ser_out), m_tx >> 7);
        chk("R5/R6 rx_vld_a", int'(rx_vld_a), m_va);
        chk("R5/R6 rx_vld_b", int'(rx_vld_b), m_vb);
        chk("R5 rx_byte", int'(rx_byte), m_rx_byte);
        chk("R5 rx_ts", int'(rx_ts), m_rx_ts);
        chk("R8 align_err", int'(align_err), m_err);
    endtask

    // Run n cycles; with aligned set, pulse on the last cycle of each frame.
    task automatic run(input int n, input bit aligned);
        for (int i = 0; i < n; i++) begin
            bit be = fast_rate ? (m_ph == 1) : 1'b1;
            cycle(aligned && be && (m_pos == FB - 1));
        end
    endtask

    initial begin
        rst_n = 1'b0; fast_rate = 1'b0; fp_pol = 1'b1; fp_in = 1'b0;
        ser_in = 1'b0; tx_byte_a = 8'h00; tx_byte_b = 8'h00;
        m_pos = 0; m_ph = 0; m_tx = 0; m_rx_sr = 0; m_rx_byte = 0;
        m_rx_ts = 0; m_va = 0; m_vb = 0; m_err = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 ser_out in reset", int'(ser_out), 0);
        chk("R1 align_err in reset", int'(align_err), 0);
        rst_n = 1'b1;
        #1;
        chk("R1 ser_out", int'(ser_out), 0);
        chk("R1 rx_vld_a", int'(rx_vld_a), 0);
        chk("R1 rx_vld_b", int'(rx_vld_b), 0);
        chk("R1 rx_byte", int'(rx_byte), 0);
        chk("R1 tx_req_a", int'(tx_req_a), 0);
        chk("R1 align_err", int'(align_err), 0);

        scen = "R10 first slot zero";
        run(8, 1'b0);

        scen = "R8 misaligned start then aligned frames";
        cycle(1'b1);
        run(2 * FB, 1'b1);

        scen = "R9 free-run without pulse";
        run(FB + 300, 1'b0);

        scen = "R8 mid-frame realign";
        cycle(1'b1);
        run(FB, 1'b1);

        scen = "R7 active-low pulse";
        fp_pol = 1'b0;
        run(FB + 40, 1'b1);
        cycle(1'b1);
        run(200, 1'b0);

        scen = "R6 double rate";
        fp_pol = 1'b1;
        fast_rate = 1'b1;
        cycle(1'b1);
        run(4 * FB, 1'b1);
        while (m_ph != 0) cycle(1'b0);
        scen = "R6 R8 realign mid-bit";
        cycle(1'b1);
        run(2 * FB + 100, 1'b0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule